// File: doc/BRIEF.md
# SMBus Transaction Sequencer

This block runs one complete SMBus master transaction on top of a byte-level I2C master engine. Software supplies a protocol type, a direction, a 7-bit target address, a command byte and, through a small internal byte buffer, the data to send or the space for the data that comes back. One `start` pulse launches the transaction. The sequencer then walks the combined-format flow: address, command, repeated START and data phases. It answers each status event from the engine with the next byte, a START or STOP request, or an ACK-control update. At the end it returns a result code with a one-cycle `done` pulse.

The engine reports each finished byte, a bus error, a negative acknowledge or lost mastership through a status event. The sequencer hands bytes to the engine with `eng_tx_valid`/`eng_tx_byte`. It drives `eng_nack_next` so that the engine NACKs the final byte of a read. A watchdog counter aborts a transaction that stops receiving events.

Top module: `smbus_seq`

## Requirements
- R1: After reset `busy`, `done`, `eng_start_req`, `eng_stop_req`, `eng_tx_valid`, `eng_clr_status`, `eng_nack_next`, `need_reset` and `idle_warn` are all 0.
- R2: An accepted `start` in idle pulses `eng_start_req` and raises `busy` one cycle later. Protocol codes are 0 quick, 1 byte, 2 byte-data, 3 word-data and 4 block-data. Quick and byte go straight to the target phase: the first event sends {addr, rd}, with the R/W bit as bit 0. All other protocols first send {addr, 0} and then the command byte.
- R3: For a read with a command phase, the event that follows the command byte pulses `eng_start_req` again and sends {addr, 1}.
- R4: `eng_nack_next` is 1 exactly while the next byte to be received is the last one of the read. It is 0 while two or more bytes remain.
- R5: In a read, each event stores `ev_rx_data` into the buffer at consecutive indices, starting at 0 (or at 1 for block-data). The last byte produces `done` with result OK (code 0) and a STOP request.
- R6: In a write, each event sends the next data byte. The event that arrives with nothing left to send requests STOP and produces `done` with result OK. A byte-protocol write sends the command byte as its single data byte.
- R7: Byte and byte-data move 1 byte, and word-data moves 2 bytes, buffer index 0 first (low byte). Block-data takes its count from buffer index 0, and its data lies at indices 1 upward.
- R8: An event with `ev_bus_err`=1 or `ev_master`=0 ends the transfer with result I/O error (code 2) and no STOP request. `need_reset` is then set and stays set until the next accepted start.
- R9: An event with `ev_nack`=1 (and no error) ends the transfer with result no-device (code 1). It pulses `eng_stop_req` and `eng_clr_status` together with `done`.
- R10: A start with a zero-length read (quick read, or block read with count 0), or with a protocol code above 4, produces `done` with result invalid (code 3) on the next cycle. No START request is issued and `busy` stays 0.
- R11: While busy, `TMO_CYCLES` cycles without an event abort the transfer with result I/O error and set `need_reset`. Each event restarts the count.
- R12: An error-free event seen while idle changes no output except `idle_warn`, which it sets and which stays set until reset. A `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a transaction (taken only when idle) |
| proto | input | 3 | Protocol code (0 quick, 1 byte, 2 byte-data, 3 word, 4 block) |
| rd | input | 1 | 1 = read, 0 = write |
| addr | input | 7 | Target address |
| cmd | input | 8 | Command byte |
| buf_wr_en | input | 1 | Software write strobe into the byte buffer |
| buf_wr_idx | input | IW | Software write index |
| buf_wr_data | input | 8 | Software write data |
| buf_rd_idx | input | IW | Software read index |
| buf_rd_data | output | 8 | Buffer content at `buf_rd_idx` |
| ev_valid | input | 1 | Engine status event |
| ev_bus_err | input | 1 | Event flag: bus error |
| ev_nack | input | 1 | Event flag: negative acknowledge |
| ev_master | input | 1 | Event flag: engine still owns the bus |
| ev_rx_data | input | 8 | Byte received by the engine |
| eng_start_req | output | 1 | Pulse: issue START / repeated START |
| eng_stop_req | output | 1 | Pulse: issue STOP |
| eng_tx_valid | output | 1 | Pulse: `eng_tx_byte` is to be sent |
| eng_tx_byte | output | 8 | Byte for the engine |
| eng_nack_next | output | 1 | Engine NACKs the next received byte |
| eng_clr_status | output | 1 | Pulse: clear NACK and stall-after-start status |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| result | output | 2 | 0 OK, 1 no-device, 2 I/O error, 3 invalid |
| need_reset | output | 1 | Engine must be reset before further use |
| idle_warn | output | 1 | Sticky: event arrived while idle |

## Verification
The hardest situation to reach is a timeout that fires only after the watchdog has already been restarted mid-transfer. It needs a transaction that keeps getting events at gaps just under the limit and then goes silent. The bench spaces events `TMO_CYCLES-5` cycles apart through the address and command phases and then waits. It checks that `done` is still low one cycle before the limit and high exactly at it. The NACK-arming point of a multi-byte read is also checked cycle by cycle, across the repeated START.

// File: rtl/smbus_seq_pkg.sv
// Shared encodings for the SMBus transaction sequencer.
// Assumes: protocol and result codes are fixed by the software interface.
package smbus_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_CMD, ST_RSTART, ST_QUICK, ST_READ, ST_WRITE
    } seq_state_t;

    localparam logic [2:0] PR_QUICK = 3'd0;
    localparam logic [2:0] PR_BYTE  = 3'd1;
    localparam logic [2:0] PR_BDATA = 3'd2;
    localparam logic [2:0] PR_WORD  = 3'd3;
    localparam logic [2:0] PR_BLOCK = 3'd4;

    localparam logic [1:0] RES_OK    = 2'd0;
    localparam logic [1:0] RES_NODEV = 2'd1;
    localparam logic [1:0] RES_IOERR = 2'd2;
    localparam logic [1:0] RES_INVAL = 2'd3;
endpackage

// File: rtl/smbus_seq_buf.sv
// Byte buffer shared by software and the sequencer.
// Two write ports (sequencer wins on a same-index clash), two combinational
// read ports. Assumes DEPTH is a power of two so indices wrap.
module smbus_seq_buf #(
    parameter int DEPTH = 8,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          f_we,
    input  logic [IW-1:0] f_idx,
    input  logic [7:0]    f_wdata,
    input  logic          s_we,
    input  logic [IW-1:0] s_idx,
    input  logic [7:0]    s_wdata,
    input  logic [IW-1:0] a_idx,
    output logic [7:0]    a_rdata,
    input  logic [IW-1:0] b_idx,
    output logic [7:0]    b_rdata
);
    logic [7:0] mem [DEPTH];

    // Storage update: sequencer write first, then software write.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (f_we && f_idx == IW'(i))
                mem[i] <= f_wdata;
            else if (s_we && s_idx == IW'(i))
                mem[i] <= s_wdata;
        end
    end

    assign a_rdata = mem[a_idx];
    assign b_rdata = mem[b_idx];
endmodule

// File: rtl/smbus_seq_tmo.sv
// Event watchdog: counts cycles while run is high, restarts on kick,
// flags expire in the cycle the count reaches TMO_CYCLES-1.
// Assumes TMO_CYCLES >= 2.
module smbus_seq_tmo #(
    parameter int TMO_CYCLES = 50000,
    localparam int CW = $clog2(TMO_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic kick,
    output logic expire
);
    logic [CW-1:0] cnt;

    // Count idle cycles of a running transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || kick)
            cnt <= '0;
        else if (cnt != CW'(TMO_CYCLES - 1))
            cnt <= cnt + 1'b1;
    end

    assign expire = run && !kick && (cnt == CW'(TMO_CYCLES - 1));
endmodule

// File: rtl/smbus_seq_fsm.sv
// Transaction state machine. Reacts to engine events, emits START/STOP,
// bytes and ACK control, writes received bytes into the buffer.
// Assumes at most one event per cycle and events only after a request.
module smbus_seq_fsm
    import smbus_seq_pkg::*;
#(
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    proto,
    input  logic          rd,
    input  logic [6:0]    addr,
    input  logic [7:0]    cmd,
    input  logic          ev_valid,
    input  logic          ev_bus_err,
    input  logic          ev_nack,
    input  logic          ev_master,
    input  logic [7:0]    ev_rx_data,
    input  logic          tmo_expire,
    input  logic [7:0]    buf_rdata,
    output logic [IW-1:0] ptr,
    output logic          buf_we,
    output logic [7:0]    buf_wdata,
    output logic          start_req,
    output logic          stop_req,
    output logic          tx_valid,
    output logic [7:0]    tx_byte,
    output logic          nack_next,
    output logic          clr_status,
    output logic          busy,
    output logic          done,
    output logic [1:0]    result,
    output logic          need_reset,
    output logic          idle_warn
);
    seq_state_t state;
    logic [7:0] len;
    logic       rd_r, byte_wr;
    logic [6:0] addr_r;
    logic [7:0] cmd_r;
    logic [7:0] start_len;
    logic       bad_req, ev_fault, ev_ok;

    // Length and validity of a request, from the protocol code.
    always_comb begin
        case (proto)
            PR_QUICK:          start_len = 8'd0;
            PR_BYTE, PR_BDATA: start_len = 8'd1;
            PR_WORD:           start_len = 8'd2;
            default:           start_len = buf_rdata;
        endcase
        bad_req = (proto > PR_BLOCK) || (rd && start_len == 8'd0);
    end

    assign ev_fault  = ev_valid && (ev_bus_err || !ev_master);
    assign ev_ok     = ev_valid && !ev_bus_err && ev_master && !ev_nack;
    assign busy      = (state != ST_IDLE);
    assign buf_we    = (state == ST_READ) && ev_ok;
    assign buf_wdata = ev_rx_data;

    // Sequencer registers and one-cycle request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            len        <= '0;
            ptr        <= '0;
            rd_r       <= 1'b0;
            byte_wr    <= 1'b0;
            addr_r     <= '0;
            cmd_r      <= '0;
            start_req  <= 1'b0;
            stop_req   <= 1'b0;
            tx_valid   <= 1'b0;
            tx_byte    <= '0;
            nack_next  <= 1'b0;
            clr_status <= 1'b0;
            done       <= 1'b0;
            result     <= RES_OK;
            need_reset <= 1'b0;
            idle_warn  <= 1'b0;
        end else begin
            start_req  <= 1'b0;
            stop_req   <= 1'b0;
            tx_valid   <= 1'b0;
            clr_status <= 1'b0;
            done       <= 1'b0;
            if (state == ST_IDLE) begin
                if (ev_valid && !ev_bus_err && !ev_nack)
                    idle_warn <= 1'b1;
                if (start && bad_req) begin
                    done   <= 1'b1;
                    result <= RES_INVAL;
                end else if (start) begin
                    start_req  <= 1'b1;
                    need_reset <= 1'b0;
                    len        <= start_len;
                    ptr        <= (proto == PR_BLOCK) ? IW'(1) : '0;
                    rd_r       <= rd;
                    addr_r     <= addr;
                    cmd_r      <= cmd;
                    byte_wr    <= (proto == PR_BYTE) && !rd;
                    state      <= (proto == PR_QUICK || proto == PR_BYTE) ? ST_QUICK : ST_ADDR;
                end
            end else if (ev_fault || (!ev_valid && tmo_expire)) begin
                state      <= ST_IDLE;
                ptr        <= '0;
                nack_next  <= 1'b0;
                done       <= 1'b1;
                result     <= RES_IOERR;
                need_reset <= 1'b1;
            end else if (ev_valid && ev_nack) begin
                state      <= ST_IDLE;
                ptr        <= '0;
                nack_next  <= 1'b0;
                done       <= 1'b1;
                result     <= RES_NODEV;
                stop_req   <= 1'b1;
                clr_status <= 1'b1;
            end else if (ev_ok) begin
                case (state)
                    ST_ADDR: begin
                        tx_valid <= 1'b1;
                        tx_byte  <= {addr_r, 1'b0};
                        state    <= ST_CMD;
                    end
                    ST_CMD: begin
                        tx_valid <= 1'b1;
                        tx_byte  <= cmd_r;
                        state    <= rd_r ? ST_RSTART : ST_WRITE;
                    end
                    ST_RSTART, ST_QUICK: begin
                        start_req <= (state == ST_RSTART);
                        tx_valid  <= 1'b1;
                        tx_byte   <= {addr_r, rd_r};
                        nack_next <= rd_r && (len == 8'd1);
                        state     <= rd_r ? ST_READ : ST_WRITE;
                    end
                    ST_READ: begin
                        ptr       <= ptr + 1'b1;
                        len       <= len - 1'b1;
                        nack_next <= (len == 8'd2);
                        if (len == 8'd1) begin
                            state     <= ST_IDLE;
                            ptr       <= '0;
                            nack_next <= 1'b0;
                            done      <= 1'b1;
                            result    <= RES_OK;
                            stop_req  <= 1'b1;
                        end
                    end
                    ST_WRITE: begin
                        if (len == 8'd0) begin
                            state    <= ST_IDLE;
                            ptr      <= '0;
                            done     <= 1'b1;
                            result   <= RES_OK;
                            stop_req <= 1'b1;
                        end else begin
                            tx_valid <= 1'b1;
                            tx_byte  <= byte_wr ? cmd_r : buf_rdata;
                            ptr      <= ptr + 1'b1;
                            len      <= len - 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/smbus_seq.sv
// SMBus transaction sequencer top: wires the buffer, watchdog and FSM.
// Assumes a byte-level engine that raises one status event per phase.
module smbus_seq #(
    parameter int DEPTH      = 8,
    parameter int TMO_CYCLES = 50000,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    proto,
    input  logic          rd,
    input  logic [6:0]    addr,
    input  logic [7:0]    cmd,
    input  logic          buf_wr_en,
    input  logic [IW-1:0] buf_wr_idx,
    input  logic [7:0]    buf_wr_data,
    input  logic [IW-1:0] buf_rd_idx,
    output logic [7:0]    buf_rd_data,
    input  logic          ev_valid,
    input  logic          ev_bus_err,
    input  logic          ev_nack,
    input  logic          ev_master,
    input  logic [7:0]    ev_rx_data,
    output logic          eng_start_req,
    output logic          eng_stop_req,
    output logic          eng_tx_valid,
    output logic [7:0]    eng_tx_byte,
    output logic          eng_nack_next,
    output logic          eng_clr_status,
    output logic          busy,
    output logic          done,
    output logic [1:0]    result,
    output logic          need_reset,
    output logic          idle_warn
);
    logic [IW-1:0] ptr;
    logic [7:0]    f_rdata, f_wdata;
    logic          f_we, expire;

    smbus_seq_buf #(.DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .f_we(f_we), .f_idx(ptr), .f_wdata(f_wdata),
        .s_we(buf_wr_en), .s_idx(buf_wr_idx), .s_wdata(buf_wr_data),
        .a_idx(ptr), .a_rdata(f_rdata),
        .b_idx(buf_rd_idx), .b_rdata(buf_rd_data)
    );

    smbus_seq_tmo #(.TMO_CYCLES(TMO_CYCLES)) u_tmo (
        .clk(clk), .rst_n(rst_n), .run(busy), .kick(ev_valid), .expire(expire)
    );

    smbus_seq_fsm #(.IW(IW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start(start), .proto(proto), .rd(rd), .addr(addr), .cmd(cmd),
        .ev_valid(ev_valid), .ev_bus_err(ev_bus_err), .ev_nack(ev_nack),
        .ev_master(ev_master), .ev_rx_data(ev_rx_data),
        .tmo_expire(expire), .buf_rdata(f_rdata),
        .ptr(ptr), .buf_we(f_we), .buf_wdata(f_wdata),
        .start_req(eng_start_req), .stop_req(eng_stop_req),
        .tx_valid(eng_tx_valid), .tx_byte(eng_tx_byte),
        .nack_next(eng_nack_next), .clr_status(eng_clr_status),
        .busy(busy), .done(done), .result(result),
        .need_reset(need_reset), .idle_warn(idle_warn)
    );
endmodule

// File: rtl/smbus_seq_chk.sv
// Protocol checker for smbus_seq, attached through bind.
module smbus_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [2:0] proto,
    input logic       busy,
    input logic       done,
    input logic [1:0] result,
    input logic       start_req,
    input logic       stop_req,
    input logic       clr_status,
    input logic       need_reset,
    input logic       idle_warn
);
    a_r2_start_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> start_req);
    a_r2_no_req_clash: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_req && stop_req));
    a_r1_done_is_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r6_ok_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 2'd0) |-> stop_req);
    a_r8_ioerr_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 2'd2) |-> (need_reset && !stop_req));
    a_r9_nodev_stop_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 2'd1) |-> (stop_req && clr_status));
    a_r10_invalid_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && proto > 3'd4) |=> (done && result == 2'd3 && !start_req && !busy));
    a_r12_warn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        idle_warn |=> idle_warn);
endmodule

bind smbus_seq smbus_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .proto(proto), .busy(busy),
    .done(done), .result(result), .start_req(eng_start_req),
    .stop_req(eng_stop_req), .clr_status(eng_clr_status),
    .need_reset(need_reset), .idle_warn(idle_warn)
);

// File: tb/smbus_seq_tb.sv
// Directed bench: one task per scenario; inputs change and outputs are
// sampled at the falling edge.
module smbus_seq_tb;
    localparam int TMO = 20;
    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 0, rd = 0, buf_wr_en = 0;
    logic [2:0] proto = 0;
    logic [6:0] addr = 0;
    logic [7:0] cmd = 0, buf_wr_data = 0, ev_rx_data = 0;
    logic [2:0] buf_wr_idx = 0, buf_rd_idx = 0;
    logic ev_valid = 0, ev_bus_err = 0, ev_nack = 0, ev_master = 1;
    logic [7:0] buf_rd_data, eng_tx_byte;
    logic eng_start_req, eng_stop_req, eng_tx_valid, eng_nack_next, eng_clr_status;
    logic busy, done, need_reset, idle_warn;
    logic [1:0] result;
    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    smbus_seq #(.DEPTH(8), .TMO_CYCLES(TMO)) u_dut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load(input int idx, input logic [7:0] d);
        buf_wr_en = 1; buf_wr_idx = 3'(idx); buf_wr_data = d;
        @(negedge clk);
        buf_wr_en = 0;
    endtask

    task automatic peek(input string tag, input int idx, input logic [7:0] exp);
        buf_rd_idx = 3'(idx); #1;
        check(tag, buf_rd_data, exp);
    endtask

    task automatic go(input logic [2:0] p, input logic r, input logic [6:0] a, input logic [7:0] c);
        start = 1; proto = p; rd = r; addr = a; cmd = c;
        @(negedge clk);
        start = 0;
    endtask

    task automatic ev(input logic be, input logic nk, input logic ms, input logic [7:0] rx);
        ev_valid = 1; ev_bus_err = be; ev_nack = nk; ev_master = ms; ev_rx_data = rx;
        @(negedge clk);
        ev_valid = 0; ev_bus_err = 0; ev_nack = 0; ev_master = 1;
    endtask

    task automatic expect_tx(input string tag, input logic [7:0] b);
        check({tag, " tx_valid"}, eng_tx_valid, 1);
        check({tag, " tx_byte"}, eng_tx_byte, b);
    endtask

    task automatic expect_end(input string tag, input logic [1:0] res, input logic stp);
        check({tag, " done"}, done, 1);
        check({tag, " result"}, result, res);
        check({tag, " stop_req"}, eng_stop_req, stp);
        check({tag, " busy"}, busy, 0);
    endtask

    task automatic t_reset();
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 reqs", {eng_start_req, eng_stop_req, eng_tx_valid, eng_clr_status, eng_nack_next}, 0);
        check("R1 flags", {need_reset, idle_warn}, 0);
    endtask

    task automatic t_bdata_write();
        load(0, 8'h3C);
        go(3'd2, 0, 7'h50, 8'hA5);
        check("R2 start_req", eng_start_req, 1);
        check("R2 busy", busy, 1);
        ev(0, 0, 1, 0); expect_tx("R2 addr w", 8'hA0);
        ev(0, 0, 1, 0); expect_tx("R2 cmd", 8'hA5);
        ev(0, 0, 1, 0); expect_tx("R7 bdata byte", 8'h3C);
        ev(0, 0, 1, 0); expect_end("R6 bdata end", 2'd0, 1);
    endtask

    task automatic t_word_read();
        go(3'd3, 1, 7'h1B, 8'h07);
        ev(0, 0, 1, 0); expect_tx("R2 word addr", 8'h36);
        ev(0, 0, 1, 0); expect_tx("R2 word cmd", 8'h07);
        ev(0, 0, 1, 0);
        check("R3 rstart", eng_start_req, 1);
        expect_tx("R3 addr r", 8'h37);
        check("R4 two left", eng_nack_next, 0);
        ev(0, 0, 1, 8'h11);
        check("R4 one left", eng_nack_next, 1);
        check("R5 not done", done, 0);
        ev(0, 0, 1, 8'h22);
        expect_end("R5 word end", 2'd0, 1);
        peek("R7 word low", 0, 8'h11);
        peek("R7 word high", 1, 8'h22);
    endtask

    task automatic t_byte_write();
        go(3'd1, 0, 7'h50, 8'h5E);
        ev(0, 0, 1, 0); expect_tx("R2 byte direct addr", 8'hA0);
        ev(0, 0, 1, 0); expect_tx("R6 byte sends cmd", 8'h5E);
        ev(0, 0, 1, 0); expect_end("R6 byte end", 2'd0, 1);
    endtask

    task automatic t_byte_read();
        go(3'd1, 1, 7'h21, 8'h00);
        ev(0, 0, 1, 0); expect_tx("R2 byte read addr", 8'h43);
        check("R4 single", eng_nack_next, 1);
        check("R2 no rstart", eng_start_req, 0);
        ev(0, 0, 1, 8'h99);
        expect_end("R5 byte read end", 2'd0, 1);
        peek("R5 byte stored", 0, 8'h99);
    endtask

    task automatic t_quick();
        go(3'd0, 0, 7'h33, 8'h00);
        ev(0, 0, 1, 0); expect_tx("R2 quick addr", 8'h66);
        ev(0, 0, 1, 0); expect_end("R6 quick end", 2'd0, 1);
        go(3'd0, 1, 7'h33, 8'h00);
        check("R10 quick read start_req", eng_start_req, 0);
        expect_end("R10 quick read", 2'd3, 0);
    endtask

    task automatic t_block();
        load(0, 8'd2); load(1, 8'hD1); load(2, 8'hD2);
        go(3'd4, 0, 7'h10, 8'h40);
        ev(0, 0, 1, 0); expect_tx("R7 blk addr", 8'h20);
        ev(0, 0, 1, 0); expect_tx("R7 blk cmd", 8'h40);
        ev(0, 0, 1, 0); expect_tx("R7 blk d1", 8'hD1);
        ev(0, 0, 1, 0); expect_tx("R7 blk d2", 8'hD2);
        ev(0, 0, 1, 0); expect_end("R7 blk end", 2'd0, 1);
        load(0, 8'd1);
        go(3'd4, 1, 7'h10, 8'h41);
        ev(0, 0, 1, 0); ev(0, 0, 1, 0);
        ev(0, 0, 1, 0); check("R4 blk single", eng_nack_next, 1);
        ev(0, 0, 1, 8'h7E); expect_end("R5 blk read end", 2'd0, 1);
        peek("R5 blk stored at 1", 1, 8'h7E);
        load(0, 8'd0);
        go(3'd4, 1, 7'h10, 8'h41);
        check("R10 zero block", eng_start_req, 0);
        expect_end("R10 zero block", 2'd3, 0);
        go(3'd6, 0, 7'h10, 8'h41);
        expect_end("R10 bad proto", 2'd3, 0);
    endtask

    task automatic t_nack();
        go(3'd2, 0, 7'h50, 8'h01);
        ev(0, 0, 1, 0);
        ev(0, 1, 1, 0);
        expect_end("R9 nack", 2'd1, 1);
        check("R9 clr_status", eng_clr_status, 1);
        check("R9 need_reset", need_reset, 0);
    endtask

    task automatic t_errors();
        go(3'd2, 0, 7'h50, 8'h01);
        ev(1, 0, 1, 0);
        expect_end("R8 bus err", 2'd2, 0);
        check("R8 need_reset", need_reset, 1);
        repeat (3) @(negedge clk);
        check("R8 need_reset held", need_reset, 1);
        go(3'd1, 0, 7'h50, 8'h01);
        check("R8 cleared on start", need_reset, 0);
        ev(0, 0, 0, 0);
        expect_end("R8 lost master", 2'd2, 0);
        check("R8 need_reset lm", need_reset, 1);
    endtask

    task automatic t_timeout();
        go(3'd2, 0, 7'h50, 8'h01);
        repeat (TMO - 5) @(negedge clk);
        ev(0, 0, 1, 0); expect_tx("R11 restart 1", 8'hA0);
        repeat (TMO - 5) @(negedge clk);
        ev(0, 0, 1, 0); expect_tx("R11 restart 2", 8'h01);
        repeat (TMO - 1) @(negedge clk);
        check("R11 not yet", done, 0);
        check("R11 still busy", busy, 1);
        @(negedge clk);
        expect_end("R11 timeout", 2'd2, 0);
        check("R11 need_reset", need_reset, 1);
    endtask

    task automatic t_idle_and_busy_start();
        ev(0, 0, 1, 8'h55);
        check("R12 warn", idle_warn, 1);
        check("R12 no tx", {eng_tx_valid, done, busy, eng_start_req, eng_stop_req}, 0);
        go(3'd1, 0, 7'h50, 8'h77);
        go(3'd3, 1, 7'h11, 8'h00);
        check("R12 busy start ignored", eng_start_req, 0);
        ev(0, 0, 1, 0); expect_tx("R12 orig addr", 8'hA0);
        ev(0, 0, 1, 0); expect_tx("R12 orig data", 8'h77);
        ev(0, 0, 1, 0); expect_end("R12 orig end", 2'd0, 1);
        check("R12 warn sticky", idle_warn, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_bdata_write();
        t_word_read();
        t_byte_write();
        t_byte_read();
        t_quick();
        t_block();
        t_nack();
        t_errors();
        t_timeout();
        t_idle_and_busy_start();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule